// File: doc/BRIEF.md
# Sequential Floating-Point Divider

This block divides one IEEE-754 binary floating-point operand by another. Its default format is single precision: 1 sign bit, 8 exponent bits and 23 fraction bits. The exponent and fraction widths are parameters. A one-cycle `start` pulse captures the dividend and divisor.

The block first screens the pair for zero, infinity and NaN operands. A screened pair finishes almost at once. Any other pair runs through a restoring significand divider that yields one quotient bit per clock. The quotient is then normalised, rounded to nearest with ties to even, and checked for exponent overflow and underflow. The sign is the exclusive-or of the operand signs.

Exponent field zero is treated as zero whatever the fraction holds, so subnormal inputs are flushed. Subnormal results are also flushed to zero. Only round-to-nearest-even is provided. `busy` blocks further requests until the single-cycle `done` pulse has been seen. The quotient and its five flags stay on the outputs until the next result replaces them.

Top module: `fp_iter_div`

## Requirements
- R1: For every result that is not NaN, the sign bit (the MSB) equals the exclusive-or of the two operand sign bits.
- R2: These cases give the canonical NaN: sign 0, exponent all ones, fraction MSB 1, other fraction bits 0.
  - Zero divided by zero and infinity divided by infinity give it with `flag_invalid` set.
  - Any NaN operand gives it with no flag set.
- R3: A divisor of zero with a nonzero dividend gives a signed infinity: exponent all ones, fraction 0.
  - `flag_divzero` is set when the dividend is finite.
  - No flag is set when the dividend is infinite.
- R4: These cases raise no flag:
  - Infinity divided by a finite nonzero value gives a signed infinity.
  - Zero divided by a finite nonzero value gives a signed zero.
  - A finite value divided by infinity gives a signed zero.
- R5: An operand whose exponent field is 0 is treated as zero regardless of its fraction bits.
- R6: For two normal operands whose quotient lands in range, the result is the exact quotient rounded to nearest with ties to even. Its biased exponent is the dividend exponent minus the divisor exponent plus the bias, less one when the dividend significand is below the divisor significand.
- R7: If the rounded biased exponent reaches the all-ones value, the result is a signed infinity with `flag_overflow` and `flag_inexact` set.
- R8: If the rounded biased exponent is 0 or below, the result is a signed zero with `flag_underflow` and `flag_inexact` set.
- R9: For in-range results of normal operands, `flag_inexact` is set exactly when the quotient is not exact. All other flags are clear.
- R10: Handshake.
  - After reset, `busy` and `done` are low.
  - A `start` sampled while idle is accepted, and `busy` stays high from the next cycle through the cycle in which `done` is high.
  - `done` is high for exactly one cycle.
  - A `start` sampled while busy is ignored.
- R11: Counting clock edges after the edge that accepts `start`, `done` is high after 1 edge for screened operand pairs and after FRAC_W+5 edges for the arithmetic path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse; operands sampled with it while idle |
| op_a | input | 1+EXP_W+FRAC_W | Dividend |
| op_b | input | 1+EXP_W+FRAC_W | Divisor |
| busy | output | 1 | High from the cycle after acceptance through the done cycle |
| done | output | 1 | One-cycle completion pulse |
| quot | output | 1+EXP_W+FRAC_W | Quotient, held until the next result |
| flag_invalid | output | 1 | Zero/zero or infinity/infinity |
| flag_divzero | output | 1 | Finite nonzero value divided by zero |
| flag_overflow | output | 1 | Result exponent too large; infinity returned |
| flag_underflow | output | 1 | Result exponent too small; zero returned |
| flag_inexact | output | 1 | Rounded or flushed result differs from exact quotient |

## Verification
The bench sweeps every dividend of a reduced 8-bit format (4 exponent bits, 3 fraction bits) against a spread of divisors. That spread includes zero, both infinities, a NaN, a subnormal and the extreme normals. Each result is checked against an integer long-division model with a remainder-based tie test.

A wrong tie break would show as off-by-one fractions on exact halfway quotients. A missed renormalisation would show when the dividend significand is smaller than the divisor's. A rounding carry not propagated into the exponent would give wrong powers of two. A wrong screening order would turn infinity/zero into NaN, or zero/zero into infinity.

Full-width directed cases target the overflow and underflow boundaries, a subnormal divisor treated as zero, and a `start` pulse issued mid-operation that must not disturb the pending result.

// File: rtl/fpdiv_pkg.sv
package fpdiv_pkg;

    typedef enum logic [1:0] {
        CLS_ZERO,
        CLS_NORM,
        CLS_INF,
        CLS_NAN
    } opclass_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ITER,
        ST_ROUND,
        ST_DONE
    } divstate_e;

    typedef struct packed {
        logic invalid;
        logic divzero;
        logic overflow;
        logic underflow;
        logic inexact;
    } dflags_t;

    localparam dflags_t NO_FLAGS = '0;

    // Exponent field zero counts as zero, subnormals included.
    function automatic opclass_e classify(input logic exp_zero,
                                          input logic exp_full,
                                          input logic frac_zero);
        if (exp_zero) return CLS_ZERO;
        if (exp_full) return frac_zero ? CLS_INF : CLS_NAN;
        return CLS_NORM;
    endfunction

endpackage

// File: rtl/fpdiv_special.sv
module fpdiv_special
    import fpdiv_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] a,
    input  logic [EXP_W+FRAC_W:0] b,
    output logic                  hit,
    output logic [EXP_W+FRAC_W:0] word,
    output dflags_t               flags
);
    localparam int WIDTH = 1 + EXP_W + FRAC_W;

    opclass_e         cls_a;
    opclass_e         cls_b;
    logic             sgn;
    logic [WIDTH-1:0] inf_w;
    logic [WIDTH-1:0] zero_w;
    logic [WIDTH-1:0] nan_w;

    assign cls_a = classify(a[FRAC_W +: EXP_W] == '0, &a[FRAC_W +: EXP_W],
                            a[FRAC_W-1:0] == '0);
    assign cls_b = classify(b[FRAC_W +: EXP_W] == '0, &b[FRAC_W +: EXP_W],
                            b[FRAC_W-1:0] == '0);
    assign sgn    = a[WIDTH-1] ^ b[WIDTH-1];
    assign inf_w  = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    assign zero_w = {sgn, {(EXP_W+FRAC_W){1'b0}}};
    assign nan_w  = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    // Priority: NaN inputs, invalid pairs, zero divisor, infinite
    // dividend, zero result; anything else goes to the arithmetic path.
    always_comb begin
        hit   = 1'b1;
        flags = NO_FLAGS;
        word  = nan_w;
        if (cls_a == CLS_NAN || cls_b == CLS_NAN) begin
            word = nan_w;
        end else if ((cls_a == CLS_ZERO && cls_b == CLS_ZERO) ||
                     (cls_a == CLS_INF  && cls_b == CLS_INF)) begin
            word          = nan_w;
            flags.invalid = 1'b1;
        end else if (cls_b == CLS_ZERO) begin
            word          = inf_w;
            flags.divzero = (cls_a == CLS_NORM);
        end else if (cls_a == CLS_INF) begin
            word = inf_w;
        end else if (cls_a == CLS_ZERO || cls_b == CLS_INF) begin
            word = zero_w;
        end else begin
            hit = 1'b0;
        end
    end

endmodule

// File: rtl/fpdiv_iter.sv
module fpdiv_iter #(
    parameter int MANT_W = 24,
    parameter int QBITS  = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [MANT_W-1:0] dividend_m,
    input  logic [MANT_W-1:0] divisor_m,
    output logic [QBITS-1:0]  quo,
    output logic              rem_nz
);
    logic [MANT_W:0]   rem_q;
    logic [MANT_W-1:0] dvs_q;
    logic [QBITS-1:0]  quo_q;
    logic              loaded_q;
    logic              fits;
    logic [MANT_W:0]   diff;
    logic [MANT_W:0]   kept;

    // One restoring step: try the subtraction, keep it if non-negative.
    assign fits = rem_q >= {1'b0, dvs_q};
    assign diff = rem_q - {1'b0, dvs_q};
    assign kept = fits ? diff : rem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q    <= '0;
            dvs_q    <= '0;
            quo_q    <= '0;
            loaded_q <= 1'b0;
        end else if (load) begin
            rem_q    <= {1'b0, dividend_m};
            dvs_q    <= divisor_m;
            quo_q    <= '0;
            loaded_q <= 1'b1;
        end else if (step) begin
            rem_q <= kept << 1;
            quo_q <= {quo_q[QBITS-2:0], fits};
        end
    end

    assign quo    = quo_q;
    assign rem_nz = rem_q != '0;

    AST_REM_BOUND: assert property (@(posedge clk) disable iff (rst)
        loaded_q |-> (rem_q < {dvs_q, 1'b0})); // R6
    AST_DIVISOR_NORM: assert property (@(posedge clk) disable iff (rst)
        loaded_q |-> dvs_q[MANT_W-1]); // R6

endmodule

// File: rtl/fpdiv_round.sv
module fpdiv_round
    import fpdiv_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [FRAC_W+2:0]       quo,
    input  logic                    rem_nz,
    input  logic                    sign,
    input  logic signed [EXP_W+1:0] exp_pre,
    output logic [EXP_W+FRAC_W:0]   word,
    output dflags_t                 flags
);
    localparam int MANT_W = FRAC_W + 1;
    localparam int QBITS  = FRAC_W + 3;
    localparam int XW     = EXP_W + 2;
    localparam logic signed [XW-1:0] EMAX_X = XW'((1 << EXP_W) - 1);
    localparam logic signed [XW-1:0] ZERO_X = '0;

    logic [MANT_W-1:0]    sig;
    logic                 g;
    logic                 s;
    logic                 up;
    logic [MANT_W:0]      sum;
    logic signed [XW-1:0] e;
    logic signed [XW-1:0] e_r;
    logic                 unused_hidden;

    // The quotient lies in (0.5, 2): use the top bit if set, otherwise
    // shift one place left and lower the exponent by one.
    always_comb begin
        if (quo[QBITS-1]) begin
            sig = quo[QBITS-1 -: MANT_W];
            g   = quo[1];
            s   = quo[0] | rem_nz;
            e   = exp_pre;
        end else begin
            sig = quo[QBITS-2 -: MANT_W];
            g   = quo[0];
            s   = rem_nz;
            e   = exp_pre - XW'(1);
        end
    end

    assign up            = g & (s | sig[0]);
    assign sum           = {1'b0, sig} + {{MANT_W{1'b0}}, up};
    assign e_r           = e + XW'(sum[MANT_W]);
    assign unused_hidden = sum[FRAC_W];

    always_comb begin
        flags = NO_FLAGS;
        if (e_r >= EMAX_X) begin
            word            = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            flags.overflow  = 1'b1;
            flags.inexact   = 1'b1;
        end else if (e_r <= ZERO_X) begin
            word            = {sign, {(EXP_W+FRAC_W){1'b0}}};
            flags.underflow = 1'b1;
            flags.inexact   = 1'b1;
        end else begin
            word            = {sign, e_r[EXP_W-1:0], sum[FRAC_W-1:0]};
            flags.inexact   = g | s;
        end
    end

endmodule

// File: rtl/fp_iter_div.sv
module fp_iter_div
    import fpdiv_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [EXP_W+FRAC_W:0] op_a,
    input  logic [EXP_W+FRAC_W:0] op_b,
    output logic                  busy,
    output logic                  done,
    output logic [EXP_W+FRAC_W:0] quot,
    output logic                  flag_invalid,
    output logic                  flag_divzero,
    output logic                  flag_overflow,
    output logic                  flag_underflow,
    output logic                  flag_inexact
);
    localparam int WIDTH  = 1 + EXP_W + FRAC_W;
    localparam int MANT_W = FRAC_W + 1;
    localparam int QBITS  = FRAC_W + 3;
    localparam int XW     = EXP_W + 2;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int CW     = $clog2(QBITS);

    divstate_e            state_q;
    logic [WIDTH-1:0]     a_q;
    logic [WIDTH-1:0]     b_q;
    logic [WIDTH-1:0]     res_q;
    dflags_t              flg_q;
    logic signed [XW-1:0] exp_q;
    logic                 sign_q;
    logic [CW-1:0]        cnt_q;

    logic                 sp_hit;
    logic [WIDTH-1:0]     sp_word;
    dflags_t              sp_flags;
    logic signed [XW-1:0] exp_diff;
    logic                 it_load;
    logic                 it_step;
    logic [QBITS-1:0]     it_quo;
    logic                 it_rem_nz;
    logic [WIDTH-1:0]     rd_word;
    dflags_t              rd_flags;

    fpdiv_special #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_special (
        .a     (a_q),
        .b     (b_q),
        .hit   (sp_hit),
        .word  (sp_word),
        .flags (sp_flags)
    );

    assign exp_diff = $signed({2'b00, a_q[FRAC_W +: EXP_W]})
                    - $signed({2'b00, b_q[FRAC_W +: EXP_W]})
                    + $signed(XW'(BIAS));
    assign it_load  = (state_q == ST_CHECK) && !sp_hit;
    assign it_step  = (state_q == ST_ITER);

    fpdiv_iter #(.MANT_W(MANT_W), .QBITS(QBITS)) u_iter (
        .clk        (clk),
        .rst        (rst),
        .load       (it_load),
        .step       (it_step),
        .dividend_m ({1'b1, a_q[FRAC_W-1:0]}),
        .divisor_m  ({1'b1, b_q[FRAC_W-1:0]}),
        .quo        (it_quo),
        .rem_nz     (it_rem_nz)
    );

    fpdiv_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
        .quo     (it_quo),
        .rem_nz  (it_rem_nz),
        .sign    (sign_q),
        .exp_pre (exp_q),
        .word    (rd_word),
        .flags   (rd_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            a_q     <= '0;
            b_q     <= '0;
            res_q   <= '0;
            flg_q   <= NO_FLAGS;
            exp_q   <= '0;
            sign_q  <= 1'b0;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        a_q     <= op_a;
                        b_q     <= op_b;
                        state_q <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (sp_hit) begin
                        res_q   <= sp_word;
                        flg_q   <= sp_flags;
                        state_q <= ST_DONE;
                    end else begin
                        exp_q   <= exp_diff;
                        sign_q  <= a_q[WIDTH-1] ^ b_q[WIDTH-1];
                        cnt_q   <= CW'(QBITS - 1);
                        state_q <= ST_ITER;
                    end
                end
                ST_ITER: begin
                    if (cnt_q == '0) state_q <= ST_ROUND;
                    else             cnt_q   <= cnt_q - CW'(1);
                end
                ST_ROUND: begin
                    res_q   <= rd_word;
                    flg_q   <= rd_flags;
                    state_q <= ST_DONE;
                end
                ST_DONE:  state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy           = (state_q != ST_IDLE);
    assign done           = (state_q == ST_DONE);
    assign quot           = res_q;
    assign flag_invalid   = flg_q.invalid;
    assign flag_divzero   = flg_q.divzero;
    assign flag_overflow  = flg_q.overflow;
    assign flag_underflow = flg_q.underflow;
    assign flag_inexact   = flg_q.inexact;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
    AST_BUSY_TILL_DONE: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy); // R10
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(a_q) && $stable(b_q))); // R10
    AST_INVALID_NAN: assert property (@(posedge clk) disable iff (rst)
        (done && flag_invalid) |->
        (&quot[FRAC_W +: EXP_W] && quot[FRAC_W-1:0] != '0)); // R2
    AST_DIVZERO_INF: assert property (@(posedge clk) disable iff (rst)
        (done && flag_divzero) |->
        (&quot[FRAC_W +: EXP_W] && quot[FRAC_W-1:0] == '0)); // R3
    AST_OVERFLOW_INF: assert property (@(posedge clk) disable iff (rst)
        (done && flag_overflow) |->
        (&quot[FRAC_W +: EXP_W] && quot[FRAC_W-1:0] == '0 && flag_inexact)); // R7
    AST_UNDERFLOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        (done && flag_underflow) |->
        (quot[EXP_W+FRAC_W-1:0] == '0 && flag_inexact)); // R8

endmodule

// File: tb/tb_fp_iter_div.sv
module tb_fp_iter_div;

    localparam int SE = 4;
    localparam int SF = 3;
    localparam int SW = 1 + SE + SF;
    localparam int WE = 8;
    localparam int WF = 23;
    localparam int WW = 1 + WE + WF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic          s_start, s_busy, s_done;
    logic [SW-1:0] s_a, s_b, s_q;
    logic          s_inv, s_dz, s_ovf, s_unf, s_inx;
    logic          w_start, w_busy, w_done;
    logic [WW-1:0] w_a, w_b, w_q;
    logic          w_inv, w_dz, w_ovf, w_unf, w_inx;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    fp_iter_div #(.EXP_W(SE), .FRAC_W(SF)) dut (
        .clk(clk), .rst(rst), .start(s_start), .op_a(s_a), .op_b(s_b),
        .busy(s_busy), .done(s_done), .quot(s_q),
        .flag_invalid(s_inv), .flag_divzero(s_dz), .flag_overflow(s_ovf),
        .flag_underflow(s_unf), .flag_inexact(s_inx)
    );

    fp_iter_div dut_w (
        .clk(clk), .rst(rst), .start(w_start), .op_a(w_a), .op_b(w_b),
        .busy(w_busy), .done(w_done), .quot(w_q),
        .flag_invalid(w_inv), .flag_divzero(w_dz), .flag_overflow(w_ovf),
        .flag_underflow(w_unf), .flag_inexact(w_inx)
    );

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // Reference: one-shot integer division, tie decided from remainder.
    // Returns {flags[4:0] = inv,dz,ovf,unf,inx ; word[31:0]}.
    function automatic logic [63:0] ref_div(input int ew, input int fw,
                                            input logic [63:0] a,
                                            input logic [63:0] b);
        longint unsigned emax, bias, fmask, sa, sb, ea, eb, fa, fb, s;
        longint unsigned ma, mb, num, q, r, nan_w, inf_w, zero_w, w;
        longint e;
        logic [4:0] fl;
        bit an, bn, ai, bi, az, bz;
        emax  = (64'd1 << ew) - 1;
        bias  = (64'd1 << (ew - 1)) - 1;
        fmask = (64'd1 << fw) - 1;
        sa = (a >> (ew + fw)) & 1;  sb = (b >> (ew + fw)) & 1;
        ea = (a >> fw) & emax;      eb = (b >> fw) & emax;
        fa = a & fmask;             fb = b & fmask;
        s  = sa ^ sb;
        an = (ea == emax) && (fa != 0);  bn = (eb == emax) && (fb != 0);
        ai = (ea == emax) && (fa == 0);  bi = (eb == emax) && (fb == 0);
        az = (ea == 0);                  bz = (eb == 0);
        nan_w  = (emax << fw) | (64'd1 << (fw - 1));
        inf_w  = (s << (ew + fw)) | (emax << fw);
        zero_w = s << (ew + fw);
        fl = 5'b0;
        w  = 0;
        if (an || bn) w = nan_w;
        else if ((az && bz) || (ai && bi)) begin w = nan_w; fl = 5'b10000; end
        else if (bz) begin w = inf_w; fl = ai ? 5'b0 : 5'b01000; end
        else if (ai) w = inf_w;
        else if (az || bi) w = zero_w;
        else begin
            ma = (64'd1 << fw) | fa;
            mb = (64'd1 << fw) | fb;
            e  = longint'(ea) - longint'(eb) + longint'(bias);
            if (ma >= mb) num = ma << fw;
            else begin num = ma << (fw + 1); e = e - 1; end
            q = num / mb;
            r = num % mb;
            if ((2 * r > mb) || ((2 * r == mb) && ((q & 1) == 1))) q = q + 1;
            if (q == (64'd1 << (fw + 1))) begin q = q >> 1; e = e + 1; end
            if (e >= longint'(emax)) begin w = inf_w; fl = 5'b00101; end
            else if (e <= 0) begin w = zero_w; fl = 5'b00011; end
            else begin
                w  = (s << (ew + fw)) | (longint'(e) << fw) | (q & fmask);
                fl = (r != 0) ? 5'b00001 : 5'b0;
            end
        end
        return {27'b0, fl, w[31:0]};
    endfunction

    function automatic string tag_for(input int ew, input int fw,
                                      input logic [63:0] a,
                                      input logic [63:0] b);
        longint unsigned emax, fmask, ea, eb, fa, fb;
        emax  = (64'd1 << ew) - 1;
        fmask = (64'd1 << fw) - 1;
        ea = (a >> fw) & emax;  eb = (b >> fw) & emax;
        fa = a & fmask;         fb = b & fmask;
        if ((ea == emax && fa != 0) || (eb == emax && fb != 0)) return "R2";
        if ((ea == 0 && eb == 0) || (ea == emax && eb == emax)) return "R2";
        if ((ea == 0 && fa != 0) || (eb == 0 && fb != 0)) return "R5";
        if (eb == 0) return "R3";
        if (ea == emax || ea == 0 || eb == emax) return "R4";
        return "R6";
    endfunction

    task automatic run_s(input logic [SW-1:0] a, input logic [SW-1:0] b,
                         output logic [SW-1:0] q, output logic [4:0] fl,
                         output int lat);
        @(negedge clk);
        s_a = a; s_b = b; s_start = 1'b1;
        @(negedge clk);
        s_start = 1'b0;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!s_done && lat < 100);
        q  = s_q;
        fl = {s_inv, s_dz, s_ovf, s_unf, s_inx};
    endtask

    task automatic run_w(input logic [WW-1:0] a, input logic [WW-1:0] b,
                         output logic [WW-1:0] q, output logic [4:0] fl,
                         output int lat);
        @(negedge clk);
        w_a = a; w_b = b; w_start = 1'b1;
        @(negedge clk);
        w_start = 1'b0;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!w_done && lat < 100);
        q  = w_q;
        fl = {w_inv, w_dz, w_ovf, w_unf, w_inx};
    endtask

    task automatic wide_case(input string tag, input logic [WW-1:0] a,
                             input logic [WW-1:0] b, input logic [WW-1:0] exp_q,
                             input logic [4:0] exp_fl, input bit special);
        logic [WW-1:0] q;
        logic [4:0]    fl;
        int            lat;
        run_w(a, b, q, fl, lat);
        check(tag, "wide quotient", 64'(q), 64'(exp_q));
        check(tag, "wide flags", 64'(fl), 64'(exp_fl));
        check("R11", "wide latency", 64'(lat), special ? 64'd1 : 64'(WF + 5));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R10 watchdog act=hung exp=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [SW-1:0] q;
        logic [4:0]    fl;
        logic [63:0]   m;
        logic [31:0]   lfsr;
        logic [31:0]   lfsr2;
        int            lat;
        int            cycles;
        s_start = 1'b0; s_a = '0; s_b = '0;
        w_start = 1'b0; w_a = '0; w_b = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10", "reset busy", 64'({s_busy, w_busy}), 64'd0);
        check("R10", "reset done", 64'({s_done, w_done}), 64'd0);

        // Handshake: 1.0 / 2.0 with a second start sent while busy.
        s_a = 8'h38; s_b = 8'h40; s_start = 1'b1;
        @(negedge clk);
        s_start = 1'b0;
        check("R10", "busy after accept", 64'(s_busy), 64'd1);
        @(negedge clk);
        s_a = 8'h48; s_b = 8'h38; s_start = 1'b1;
        @(negedge clk);
        s_start = 1'b0;
        cycles = 0;
        while (!s_done && cycles < 100) begin
            if (!s_busy) check("R10", "busy dropped early", 64'd0, 64'd1);
            @(negedge clk);
            cycles++;
        end
        check("R10", "busy in done cycle", 64'(s_busy), 64'd1);
        check("R10", "first result kept", 64'(s_q), 64'h30);
        @(negedge clk);
        check("R10", "done single cycle", 64'(s_done), 64'd0);
        check("R10", "idle after done", 64'(s_busy), 64'd0);
        repeat (12) begin
            @(negedge clk);
            if (s_done || s_busy) check("R10", "ignored start ran", 64'd1, 64'd0);
        end
        check("R10", "result held", 64'(s_q), 64'h30);

        // Sweep of the reduced format.
        for (int i = 0; i < 256; i++) begin
            for (int j = 0; j < 42; j++) begin
                logic [SW-1:0] bv;
                string         tg;
                bit            sp;
                case (j)
                    37:      bv = 8'h78;
                    38:      bv = 8'hF8;
                    39:      bv = 8'h08;
                    40:      bv = 8'h77;
                    41:      bv = 8'h01;
                    default: bv = SW'(j * 7);
                endcase
                m  = ref_div(SE, SF, 64'(i), 64'(bv));
                tg = tag_for(SE, SF, 64'(i), 64'(bv));
                sp = (i[6:3] == 4'h0) || (i[6:3] == 4'hF) ||
                     (bv[6:3] == 4'h0) || (bv[6:3] == 4'hF);
                run_s(SW'(i), bv, q, fl, lat);
                if (tg == "R6") begin
                    if (m[34]) tg = "R7";
                    else if (m[33]) tg = "R8";
                end
                check(tg, "quotient", 64'(q), 64'(m[SW-1:0]));
                check((tg == "R6") ? "R9" : tg, "flags", 64'(fl), 64'(m[36:32]));
                check("R11", "latency", 64'(lat), sp ? 64'd1 : 64'(SF + 5));
            end
        end

        // Full-width directed cases.
        wide_case("R6", 32'h40C00000, 32'h40000000, 32'h40400000, 5'b00000, 1'b0);
        wide_case("R1", 32'hC0C00000, 32'h40000000, 32'hC0400000, 5'b00000, 1'b0);
        wide_case("R1", 32'hBF400000, 32'hBF000000, 32'h3FC00000, 5'b00000, 1'b0);
        wide_case("R9", 32'h3F800000, 32'h40400000, 32'h3EAAAAAB, 5'b00001, 1'b0);
        wide_case("R7", 32'h7F7FFFFF, 32'h3F000000, 32'h7F800000, 5'b00101, 1'b0);
        wide_case("R8", 32'h00800000, 32'h40000000, 32'h00000000, 5'b00011, 1'b0);
        wide_case("R3", 32'hBF800000, 32'h00000000, 32'hFF800000, 5'b01000, 1'b1);
        wide_case("R2", 32'h00000000, 32'h80000000, 32'h7FC00000, 5'b10000, 1'b1);
        wide_case("R2", 32'h7F800000, 32'hFF800000, 32'h7FC00000, 5'b10000, 1'b1);
        wide_case("R2", 32'h7FC00001, 32'h3F800000, 32'h7FC00000, 5'b00000, 1'b1);
        wide_case("R4", 32'h40000000, 32'hFF800000, 32'h80000000, 5'b00000, 1'b1);
        wide_case("R5", 32'h00400000, 32'h3F800000, 32'h00000000, 5'b00000, 1'b1);
        wide_case("R5", 32'h3F800000, 32'h00000001, 32'h7F800000, 5'b01000, 1'b1);

        // Pseudo-random full-width normals against the reference.
        lfsr  = 32'h1357_9BDF;
        lfsr2 = 32'h2468_ACE1;
        for (int k = 0; k < 150; k++) begin
            logic [WW-1:0] wq;
            logic [WW-1:0] av;
            logic [WW-1:0] bv;
            lfsr  = lfsr ^ (lfsr << 13);  lfsr  = lfsr ^ (lfsr >> 17);  lfsr  = lfsr ^ (lfsr << 5);
            lfsr2 = lfsr2 ^ (lfsr2 << 13); lfsr2 = lfsr2 ^ (lfsr2 >> 17); lfsr2 = lfsr2 ^ (lfsr2 << 5);
            av = lfsr;
            bv = lfsr2;
            m  = ref_div(WE, WF, 64'(av), 64'(bv));
            run_w(av, bv, wq, fl, lat);
            check(tag_for(WE, WF, 64'(av), 64'(bv)), "wide random quotient",
                  64'(wq), 64'(m[31:0]));
            check("R9", "wide random flags", 64'(fl), 64'(m[36:32]));
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule